// File: doc/BRIEF.md
# Modulo Timer with Overflow Flag

This block is a free-running counter that advances on a chosen clock enable, divided by a power-of-two prescaler. It counts up to a modulo bound supplied on an input port. In up mode it wraps back to zero. In up-down mode it counts up to the bound and back down to zero. Each time the count passes the bound, a sticky overflow flag is raised. When the overflow interrupt is enabled, the flag drives an interrupt request.

Software controls the block through a single 8-bit status/control byte on a simple strobe bus. A read returns the live register. A write updates the enable and prescaler fields at once. The mode and clock-source fields take a write only while an external unlock input is high. The flag clears through a two-step handshake: a read that sees the flag set, then a write of 0 to bit 7. An overflow that lands between those two accesses keeps the flag set, so an event is never dropped.

Top module: `modulo_timer`

## Requirements
- R1: After reset the status byte reads 0x00, the count is 0 and the interrupt output is low.
- R2: The byte maps as bit 7 overflow flag, bit 6 interrupt enable, bit 5 up-down select, bits 4:3 clock source and bits 2:0 prescaler. Any write loads bits 6 and 2:0 from the write data.
- R3: Bits 5:3 take the write data only when `wp_dis` is 1; otherwise a write leaves them unchanged.
- R4: Clock source 00 halts the counter. Source 01 gives one enable every other system cycle when `fast_sel` is 0 and one every cycle when `fast_sel` is 1. Source 10 passes `fix_tick` and source 11 passes `ext_tick`; the other pulse input is ignored.
- R5: The prescaler lets one count step through per 2^PS selected enables (PS 0 to 7). Any window of k·2^PS enables yields exactly k steps.
- R6: In up mode (bit 5 = 0), a step at or above `modulo` sets the count to 0 and raises the flag. Any other step adds 1.
- R7: In up-down mode (bit 5 = 1), the count climbs to `modulo` and then falls to 0. The flag is raised on the step that turns the count at `modulo`.
- R8: The flag stays set until a write of 0 to bit 7 that follows a read which returned the flag as 1. Writing 1 to bit 7 never clears it.
- R9: An overflow after the arming read, or in the same cycle as the clearing write, leaves the flag set.
- R10: Every write discards the arming left by an earlier read. A second write without a fresh read cannot clear the flag.
- R11: `irq` is high exactly when the flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Read strobe for the status byte |
| reg_wr | input | 1 | Write strobe for the status byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current status byte |
| wp_dis | input | 1 | High to unlock bits 5:3 for writing |
| fast_sel | input | 1 | Source 01 runs undivided when high, at half rate when low |
| fix_tick | input | 1 | Fixed-rate enable pulse, one system cycle wide |
| ext_tick | input | 1 | External enable pulse, synchronised, one cycle wide |
| modulo | input | CNT_W | Count bound |
| count | output | CNT_W | Current count |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that `fix_tick` and `ext_tick` are already synchronous to `clk`. They also assume that `modulo` changes only between register accesses, so it is never sampled mid-handshake in a way the port-level properties cannot see. The random stimulus drives every input at the falling edge, pulses the enables for one cycle at a time, and holds `modulo` for 256 cycles before picking a new small bound. Prescaler values are biased low so that overflows, and therefore handshake races, happen often.

// File: rtl/mt_pkg.sv
package mt_pkg;

    localparam int PS_W  = 3;
    localparam int PRE_W = (1 << PS_W) - 1;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_SYS  = 2'b01,
        SRC_FIX  = 2'b10,
        SRC_EXT  = 2'b11
    } src_e;

    // bit order of this struct is the software-visible byte layout
    typedef struct packed {
        logic            flag;
        logic            ie;
        logic            updown;
        src_e            src;
        logic [PS_W-1:0] ps;
    } ctl_t;

endpackage

// File: rtl/mt_ctrl_reg.sv
module mt_ctrl_reg
    import mt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       wp_dis,
    input  logic       ovf,
    output ctl_t       ctl,
    output logic       irq
);

    typedef struct packed {
        ctl_t ctl;
        logic armed;
    } reg_st_t;

    reg_st_t st_d, st_q;
    ctl_t    wv;

    assign wv = ctl_t'(reg_wdata);

    always_comb begin
        st_d = st_q;

        if (reg_wr) begin
            st_d.ctl.ie = wv.ie;
            st_d.ctl.ps = wv.ps;
            if (wp_dis) begin
                st_d.ctl.updown = wv.updown;
                st_d.ctl.src    = wv.src;
            end
        end

        // arming: a read that sees the flag; lost on any overflow or write
        if (reg_rd && st_q.ctl.flag) begin
            st_d.armed = 1'b1;
        end
        if (ovf || reg_wr) begin
            st_d.armed = 1'b0;
        end

        // flag: hardware set wins over a clearing write
        if (ovf) begin
            st_d.ctl.flag = 1'b1;
        end else if (reg_wr && !wv.flag && st_q.armed) begin
            st_d.ctl.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl = st_q.ctl;
    assign irq = st_q.ctl.flag & st_q.ctl.ie;

endmodule

// File: rtl/mt_tick_sel.sv
module mt_tick_sel
    import mt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  src_e            src,
    input  logic [PS_W-1:0] ps,
    input  logic            fast_sel,
    input  logic            fix_tick,
    input  logic            ext_tick,
    output logic            tick
);

    typedef struct packed {
        logic             half;
        logic [PRE_W-1:0] pre;
    } sel_st_t;

    sel_st_t          st_d, st_q;
    logic             src_tick;
    logic [PRE_W-1:0] mask;

    // mask has the low PS bits set: a step passes when they are all 1
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (PS_W'(i) < ps);
    end

    always_comb begin
        unique case (src)
            SRC_NONE: src_tick = 1'b0;
            SRC_SYS:  src_tick = fast_sel | st_q.half;
            SRC_FIX:  src_tick = fix_tick;
            SRC_EXT:  src_tick = ext_tick;
            default:  src_tick = 1'b0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.half = (src == SRC_SYS) ? ~st_q.half : 1'b0;
        if (src == SRC_NONE) begin
            st_d.pre = '0;
        end else if (src_tick) begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = src_tick && ((st_q.pre & mask) == mask);

endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             updown,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir_up;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_top;
    logic    mod_zero;

    assign at_top   = (st_q.cnt >= modulo);
    assign mod_zero = (modulo == '0);

    always_comb begin
        st_d = st_q;
        ovf  = 1'b0;
        if (!updown) begin
            st_d.dir_up = 1'b1;
        end

        if (tick) begin
            if (!updown) begin
                if (at_top) begin
                    st_d.cnt = '0;
                    ovf      = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else if (st_q.dir_up) begin
                if (at_top) begin
                    st_d.cnt    = mod_zero ? '0 : (modulo - ONE);
                    st_d.dir_up = 1'b0;
                    ovf         = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.cnt    = mod_zero ? '0 : ONE;
                    st_d.dir_up = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir_up: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/modulo_timer.sv
module modulo_timer
    import mt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             wp_dis,
    input  logic             fast_sel,
    input  logic             fix_tick,
    input  logic             ext_tick,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    ctl_t ctl;
    logic tick;
    logic ovf;

    mt_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .wp_dis    (wp_dis),
        .ovf       (ovf),
        .ctl       (ctl),
        .irq       (irq)
    );

    mt_tick_sel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (ctl.src),
        .ps       (ctl.ps),
        .fast_sel (fast_sel),
        .fix_tick (fix_tick),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .updown (ctl.updown),
        .modulo (modulo),
        .count  (count),
        .ovf    (ovf)
    );

    assign reg_rdata = ctl;

endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [7:0]       reg_wdata,
    input logic             wp_dis,
    input logic [7:0]       reg_rdata,
    input logic [CNT_W-1:0] count,
    input logic             irq
);

    AST_LOCKED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !wp_dis) |=> (reg_rdata[5:3] == $past(reg_rdata[5:3]))); // R3

    AST_HALTED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[4:3] == 2'b00) |=> (count == $past(count))); // R4

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[5] |=> ((count == $past(count)) || (count == $past(count) + 1'b1)
                           || (count == '0))); // R6

    AST_UP_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reg_rdata[7]) && !$past(reg_rdata[5])) |-> (count == '0)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] && !(reg_wr && !reg_wdata[7])) |=> reg_rdata[7]); // R8

    AST_IRQ_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reg_rdata[7]) && reg_rdata[6]) |-> irq); // R11

    AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[6] |-> !irq); // R11

endmodule

bind modulo_timer mt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .wp_dis    (wp_dis),
    .reg_rdata (reg_rdata),
    .count     (count),
    .irq       (irq)
);

// File: tb/modulo_timer_tb.sv
`timescale 1ns/1ps
module modulo_timer_tb;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             reg_rd, reg_wr, wp_dis, fast_sel, fix_tick, ext_tick;
    logic [7:0]       reg_wdata;
    logic [7:0]       reg_rdata;
    logic [CNT_W-1:0] modulo, count;
    logic             irq;

    int n_checks = 0;
    int n_fail   = 0;
    int wd       = 0;
    bit chk_en   = 1'b0;

    always #10 clk = ~clk;

    modulo_timer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wp_dis(wp_dis),
        .fast_sel(fast_sel), .fix_tick(fix_tick), .ext_tick(ext_tick),
        .modulo(modulo), .count(count), .irq(irq)
    );

    // ---------------- reference model built from the requirements ----------
    logic             m_flag, m_ie, m_ud, m_armed, m_half, m_dir, m_src, m_tick, m_ovf;
    logic [1:0]       m_cs;
    logic [2:0]       m_ps;
    logic [6:0]       m_pre, m_mask;
    logic [CNT_W-1:0] m_cnt;

    function automatic logic [7:0] exp_byte();
        return {m_flag, m_ie, m_ud, m_cs, m_ps};
    endfunction

    function automatic logic [6:0] ps_mask(input logic [2:0] p);
        return 7'((8'd1 << p) - 8'd1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0; m_ie = 0; m_ud = 0; m_cs = 0; m_ps = 0; m_armed = 0;
            m_half = 0; m_pre = 0; m_cnt = 0; m_dir = 1;
        end else begin
            case (m_cs)
                2'b00:   m_src = 1'b0;
                2'b01:   m_src = fast_sel | m_half;
                2'b10:   m_src = fix_tick;
                default: m_src = ext_tick;
            endcase
            m_mask = ps_mask(m_ps);
            m_tick = m_src && ((m_pre & m_mask) == m_mask);
            m_half = (m_cs == 2'b01) ? ~m_half : 1'b0;
            if (m_cs == 2'b00) m_pre = 0; else if (m_src) m_pre = m_pre + 1'b1;
            m_ovf = 1'b0;
            if (!m_ud) m_dir = 1'b1;
            if (m_tick) begin
                if (!m_ud) begin
                    if (m_cnt >= modulo) begin m_cnt = 0; m_ovf = 1; end
                    else m_cnt = m_cnt + 1'b1;
                end else if (m_dir) begin
                    if (m_cnt >= modulo) begin
                        m_cnt = (modulo == 0) ? '0 : modulo - 1'b1; m_dir = 0; m_ovf = 1;
                    end else m_cnt = m_cnt + 1'b1;
                end else begin
                    if (m_cnt == 0) begin m_cnt = (modulo == 0) ? '0 : 1; m_dir = 1; end
                    else m_cnt = m_cnt - 1'b1;
                end
            end
            if (m_ovf) m_flag = 1'b1;
            else if (reg_wr && !reg_wdata[7] && m_armed) m_flag = 1'b0;
            if (reg_rd && exp_byte_flag_prev) m_armed = 1'b1;
            if (m_ovf || reg_wr) m_armed = 1'b0;
            if (reg_wr) begin
                m_ie = reg_wdata[6]; m_ps = reg_wdata[2:0];
                if (wp_dis) begin m_ud = reg_wdata[5]; m_cs = reg_wdata[4:3]; end
            end
        end
        exp_byte_flag_prev = m_flag;
    end
    logic exp_byte_flag_prev = 1'b0;

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            chk(reg_rdata == exp_byte(), "R2", "status byte", reg_rdata, exp_byte());
            chk(count == m_cnt, m_ud ? "R7" : "R6", "count", count, m_cnt);
            chk(irq == (m_flag && m_ie), "R11", "irq", irq, m_flag && m_ie);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d cycles expected completion", wd);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input logic rd, input logic wr, input logic [7:0] wd_v,
                        input logic wp, input logic fx, input logic ex);
        reg_rd = rd; reg_wr = wr; reg_wdata = wd_v; wp_dis = wp;
        fix_tick = fx; ext_tick = ex;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 0, 0);
    endtask

    task automatic wr_reg(input logic [7:0] v, input logic wp);
        step(0, 1, v, wp, 0, 0);
    endtask

    task automatic wait_wrap();
        idle(1);
        while (!(m_flag && m_cnt == 0)) idle(1);
    endtask

    logic [CNT_W-1:0] c0;

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0; wp_dis = 0;
        fast_sel = 0; fix_tick = 0; ext_tick = 0; modulo = 16'd1000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(reg_rdata == 8'h00, "R1", "reset byte", reg_rdata, 8'h00);
        chk(count == 0, "R1", "reset count", count, 0);
        chk(irq == 1'b0, "R1", "reset irq", irq, 0);
        chk_en = 1'b1;

        // R3: locked fields
        wr_reg(8'h3F, 0);
        chk(reg_rdata == 8'h07, "R3", "locked write", reg_rdata, 8'h07);
        wr_reg(8'h08, 1);
        chk(reg_rdata == 8'h08, "R3", "unlocked write", reg_rdata, 8'h08);

        // R4: source selection
        fast_sel = 0; c0 = count; idle(20);
        chk(count - c0 == 10, "R4", "half-rate steps", count - c0, 10);
        fast_sel = 1; c0 = count; idle(20);
        chk(count - c0 == 20, "R4", "full-rate steps", count - c0, 20);
        wr_reg(8'h10, 1); c0 = count;
        for (int i = 0; i < 12; i++) step(0, 0, 0, 0, (i % 2 == 0) && (i < 10), 1);
        chk(count - c0 == 5, "R4", "fixed source steps", count - c0, 5);
        wr_reg(8'h18, 1); c0 = count;
        for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1, i < 7);
        chk(count - c0 == 7, "R4", "external source steps", count - c0, 7);
        wr_reg(8'h00, 1); c0 = count;
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, 1);
        chk(count == c0, "R4", "halted", count, c0);

        // R5: prescaler
        wr_reg(8'h0B, 1); c0 = count; idle(64);
        chk(count - c0 == 8, "R5", "divide by 8", count - c0, 8);
        wr_reg(8'h0F, 1); c0 = count; idle(256);
        chk(count - c0 == 2, "R5", "divide by 128", count - c0, 2);

        // flag handshake, modulo 3, one step per cycle
        modulo = 16'd3;
        wr_reg(8'h48, 1);
        wait_wrap();
        chk(irq == 1'b1, "R11", "irq with flag", irq, 1);
        wr_reg(8'h40, 0);
        chk(reg_rdata[7] == 1'b1, "R8", "write 0 without read", reg_rdata[7], 1);
        wait_wrap();
        step(1, 0, 0, 0, 0, 0); wr_reg(8'hC0, 0);
        chk(reg_rdata[7] == 1'b1, "R8", "write 1 after read", reg_rdata[7], 1);
        wait_wrap();
        step(1, 0, 0, 0, 0, 0); wr_reg(8'hC0, 0); wr_reg(8'h40, 0);
        chk(reg_rdata[7] == 1'b1, "R10", "second write unarmed", reg_rdata[7], 1);
        wait_wrap();
        step(1, 0, 0, 0, 0, 0); wr_reg(8'h40, 0);
        chk(reg_rdata[7] == 1'b0, "R8", "armed clear", reg_rdata[7], 0);
        chk(irq == 1'b0, "R11", "irq after clear", irq, 0);
        wait_wrap();
        step(1, 0, 0, 0, 0, 0); idle(4); wr_reg(8'h40, 0);
        chk(reg_rdata[7] == 1'b1, "R9", "overflow between", reg_rdata[7], 1);
        wait_wrap();
        step(1, 0, 0, 0, 0, 0); idle(2); wr_reg(8'h40, 0);
        chk(reg_rdata[7] == 1'b1, "R9", "overflow same cycle", reg_rdata[7], 1);
        wr_reg(8'h00, 0);
        chk(irq == 1'b0, "R11", "irq disabled", irq, 0);

        // R7: up-down run, checked each cycle by the model
        wr_reg(8'h68, 1);
        idle(40);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] v;
            if (i % 256 == 0) modulo = CNT_W'($urandom % 12);
            fast_sel = ($urandom % 2) == 0;
            v = 8'($urandom);
            if (($urandom % 4) != 0) v[2:0] = 3'($urandom % 3);
            step(($urandom % 10) < 3, ($urandom % 100) < 12, v, ($urandom % 10) < 3,
                 ($urandom % 4) == 0, ($urandom % 2) == 0);
        end
        idle(2);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule